// File: doc/BRIEF.md
# Transactional Line Cache with Snoop Conflict Detection

This block is a small fully associative data cache for one core. Each line holds a tag, the line data, a coherence state (Shared or Modified) and one speculative bit. The bit marks membership in the read or write set of the running hardware transaction. Stores made inside a transaction stay in the local line until commit. Commit walks the array, one entry per cycle, and puts a modified notice carrying the line data on a snoop bus for every line the transaction wrote.

Caches of several cores share the snoop bus. A cache that receives a modified notice for a line in its own speculative set aborts its transaction. Conflicts are tracked per whole line, so a store to one word of a line aborts a reader of another word of the same line. An optional eager mode puts a speculative-write notice on the bus at store time, so a conflicting reader aborts before the writer commits. A transaction that needs a new line while every entry is speculative aborts for lack of capacity. Stores outside a transaction write through at once with a modified notice.

Top module: `txcache`

## Requirements
- R1: A transactional load that misses puts a read message (kind 0) for the line on the snoop bus one cycle after the request. It installs the line as Shared with the speculative bit set and returns the addressed word. A later load to that line produces no bus message.
- R2: A transactional store changes only the local line, which becomes Modified and speculative. With eager mode off, a store hit sends nothing on the bus, a store miss sends only a read message, and the shared memory keeps its old value until commit.
- R3: A commit request in a transaction scans every entry. It sends one modified notice (kind 1, with line data) for each Modified line, clears all speculative bits, then pulses the commit-done output for one cycle. Committed data stays readable locally without bus traffic.
- R4: An incoming modified notice whose line matches a local speculative line aborts the transaction. The abort output pulses for exactly one cycle and the in-transaction output falls.
- R5: Conflicts are detected per line. With two words per line (word = address bit 0, line = the remaining address bits), a committed store to one word aborts a transaction that only read the other word.
- R6: A transactional miss takes an invalid entry, else the lowest non-speculative entry, without aborting. When every entry is speculative, the miss aborts the transaction and returns no data.
- R7: With eager mode on, every transactional store sends a speculative-write notice (kind 2). A receiver holding that line speculatively aborts on the following cycle, and the sender stays in its transaction.
- R8: On abort, lines that are Modified and speculative are invalidated, so a later load returns the memory value. Speculative bits of read-only lines are cleared.
- R9: Accesses outside a transaction never abort. A store outside a transaction sends a modified notice with the new line data in the next cycle.
- R10: A begin request during a transaction is ignored and the existing read set stays tracked. A commit request with no transaction active produces no bus message and no commit-done pulse.
- R11: An incoming modified notice invalidates a matching non-speculative line, so the next load fetches the new memory value.
- R12: After reset no transaction is active, and the abort, commit-done, response-valid and bus-valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eager_en | input | 1 | Send a speculative-write notice at each transactional store |
| tx_begin | input | 1 | Start a transaction |
| tx_commit | input | 1 | Commit the running transaction |
| req_valid | input | 1 | Load or store request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| fill_line | input | WORDS*DATA_W | Memory contents of the requested line, used on a miss |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | DATA_W | Load data |
| in_tx | output | 1 | Transaction active |
| tx_abort | output | 1 | One-cycle abort pulse |
| tx_done | output | 1 | One-cycle commit-complete pulse |
| snp_out_valid | output | 1 | Outgoing bus message valid |
| snp_out_kind | output | 2 | 0 read, 1 modified, 2 speculative write |
| snp_out_line | output | ADDR_W-log2(WORDS) | Line address of the outgoing message |
| snp_out_data | output | WORDS*DATA_W | Line data for modified notices |
| snp_in_valid | input | 1 | Incoming bus message valid |
| snp_in_kind | input | 2 | Incoming message kind, same code as outgoing |
| snp_in_line | input | ADDR_W-log2(WORDS) | Incoming line address |

## Verification
The bench builds two caches with three entries each, 8-bit addresses and data, and two words per line. It cross-connects their snoop buses over a shared memory model. Three entries let a four-line read sequence reach the capacity abort in a few cycles. Two words per line bring false sharing within reach with adjacent addresses. The pair of caches is enough for the crossed read-A/write-B scenario, eager notices and commit-time aborts.

// File: rtl/txc_pkg.sv
package txc_pkg;
    typedef enum logic [1:0] {
        MSG_READ = 2'd0,
        MSG_MOD  = 2'd1,
        MSG_SPEC = 2'd2
    } msg_kind_e;

    typedef enum logic {
        ST_SHARED = 1'b0,
        ST_MOD    = 1'b1
    } line_st_e;

    typedef enum logic {
        PH_RUN   = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;
endpackage

// File: rtl/txc_match.sv
module txc_match #(
    parameter int N     = 4,
    parameter int TAG_W = 7
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic [N-1:0]            hit_vec
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = vld[i] && (tags[i] == key);
    end
endmodule

// File: rtl/txc_pick.sv
module txc_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     hit_vec,
    input  logic [N-1:0]     vld,
    input  logic [N-1:0]     spec,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic             room,
    output logic [IDX_W-1:0] vic_idx
);
    logic [N-1:0] free_v;
    logic [N-1:0] spare_v;

    assign free_v  = ~vld;
    assign spare_v = vld & ~spec;
    assign hit     = |hit_vec;
    assign room    = (|free_v) || (|spare_v);

    // lowest index wins; an invalid entry beats a clean valid one
    always_comb begin
        hit_idx = '0;
        vic_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
            if (spare_v[i]) vic_idx = IDX_W'(i);
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (free_v[i]) vic_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/txcache.sv
module txcache
    import txc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int WORDS   = 2,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eager_en,
    input  logic              tx_begin,
    input  logic              tx_commit,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LINE_W-1:0] fill_line,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              in_tx,
    output logic              tx_abort,
    output logic              tx_done,
    output logic              snp_out_valid,
    output logic [1:0]        snp_out_kind,
    output logic [TAG_W-1:0]  snp_out_line,
    output logic [LINE_W-1:0] snp_out_data,
    input  logic              snp_in_valid,
    input  logic [1:0]        snp_in_kind,
    input  logic [TAG_W-1:0]  snp_in_line
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic              vld;
        logic              spec;
        line_st_e          st;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] data;
    } entry_t;

    function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                   input logic [OFF_W-1:0] off,
                                                   input logic [DATA_W-1:0] w);
        logic [LINE_W-1:0] r;
        r = line;
        r[off*DATA_W +: DATA_W] = w;
        return r;
    endfunction

    entry_t ent   [ENTRIES];
    entry_t ent_n [ENTRIES];
    logic       act, act_n;
    phase_e     ph, ph_n;
    logic [IDX_W-1:0] scan, scan_n;

    logic [ENTRIES-1:0]            vld_v, spec_v, dirty_v;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_v;
    for (genvar i = 0; i < ENTRIES; i++) begin : g_flat
        assign vld_v[i]   = ent[i].vld;
        assign spec_v[i]  = ent[i].spec;
        assign dirty_v[i] = ent[i].vld && (ent[i].st == ST_MOD);
        assign tag_v[i]   = ent[i].tag;
    end

    logic [TAG_W-1:0] key;
    logic [OFF_W-1:0] off;
    assign key = req_addr[ADDR_W-1:OFF_W];
    assign off = req_addr[OFF_W-1:0];

    logic [ENTRIES-1:0] req_hits, snp_hits;
    logic               hit, room;
    logic [IDX_W-1:0]   hit_idx, vic_idx;

    txc_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_req_match (
        .vld(vld_v), .tags(tag_v), .key(key), .hit_vec(req_hits));
    txc_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_snp_match (
        .vld(vld_v), .tags(tag_v), .key(snp_in_line), .hit_vec(snp_hits));
    txc_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .hit_vec(req_hits), .vld(vld_v), .spec(spec_v),
        .hit(hit), .hit_idx(hit_idx), .room(room), .vic_idx(vic_idx));

    logic in_mod, in_spec, clash, draining;
    assign draining = (ph == PH_DRAIN);
    assign in_mod   = snp_in_valid && (snp_in_kind == MSG_MOD);
    assign in_spec  = snp_in_valid && (snp_in_kind == MSG_SPEC);
    assign clash    = act && !draining && (in_mod || in_spec) && (|(snp_hits & spec_v));

    logic              rv_n, ab_n, dn_n, bv_n;
    logic [DATA_W-1:0] rd_n;
    msg_kind_e         bk_n;
    logic [TAG_W-1:0]  bl_n;
    logic [LINE_W-1:0] bd_n;
    logic [LINE_W-1:0] newline;
    logic              kill;

    always_comb begin
        ent_n   = ent;
        act_n   = act;
        ph_n    = ph;
        scan_n  = scan;
        rv_n    = 1'b0;
        rd_n    = '0;
        ab_n    = 1'b0;
        dn_n    = 1'b0;
        bv_n    = 1'b0;
        bk_n    = MSG_READ;
        bl_n    = key;
        bd_n    = '0;
        kill    = 1'b0;
        newline = req_we ? put_word(fill_line, off, req_wdata) : fill_line;

        // a remote commit or write-through makes the local copy stale
        if (in_mod) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (snp_hits[i] && !(draining && ent[i].st == ST_MOD)) begin
                    ent_n[i].vld  = 1'b0;
                    ent_n[i].spec = 1'b0;
                end
            end
        end

        if (draining) begin
            if (ent[scan].vld && ent[scan].st == ST_MOD) begin
                bv_n = 1'b1;
                bk_n = MSG_MOD;
                bl_n = ent[scan].tag;
                bd_n = ent[scan].data;
                ent_n[scan].st = ST_SHARED;
            end
            ent_n[scan].spec = 1'b0;
            if (scan == LAST) begin
                ph_n  = PH_RUN;
                act_n = 1'b0;
                dn_n  = 1'b1;
            end else begin
                scan_n = scan + 1'b1;
            end
        end else if (clash) begin
            kill = 1'b1;
        end else begin
            if (tx_begin && !act) act_n = 1'b1;
            if (tx_commit && act) begin
                ph_n   = PH_DRAIN;
                scan_n = '0;
            end else if (req_valid) begin
                if (hit) begin
                    if (req_we) begin
                        ent_n[hit_idx].data = put_word(ent[hit_idx].data, off, req_wdata);
                        if (act) begin
                            ent_n[hit_idx].spec = ent_n[hit_idx].vld;
                            ent_n[hit_idx].st   = ST_MOD;
                            bv_n = eager_en;
                            bk_n = MSG_SPEC;
                        end else begin
                            bv_n = 1'b1;
                            bk_n = MSG_MOD;
                        end
                        bd_n = ent_n[hit_idx].data;
                    end else begin
                        rv_n = 1'b1;
                        rd_n = ent[hit_idx].data[off*DATA_W +: DATA_W];
                        if (act) ent_n[hit_idx].spec = ent_n[hit_idx].vld;
                    end
                end else if (room) begin
                    ent_n[vic_idx].vld  = 1'b1;
                    ent_n[vic_idx].spec = act;
                    ent_n[vic_idx].st   = (act && req_we) ? ST_MOD : ST_SHARED;
                    ent_n[vic_idx].tag  = key;
                    ent_n[vic_idx].data = newline;
                    bv_n = 1'b1;
                    bd_n = newline;
                    if (!req_we)     bk_n = MSG_READ;
                    else if (!act)   bk_n = MSG_MOD;
                    else if (eager_en) bk_n = MSG_SPEC;
                    else             bk_n = MSG_READ;
                    if (!req_we) begin
                        rv_n = 1'b1;
                        rd_n = fill_line[off*DATA_W +: DATA_W];
                    end
                end else begin
                    // every entry speculative: only possible inside a transaction
                    kill = 1'b1;
                end
            end
        end

        if (kill) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (ent[i].spec && ent[i].st == ST_MOD) ent_n[i].vld = 1'b0;
                ent_n[i].spec = 1'b0;
                ent_n[i].st   = ST_SHARED;
            end
            act_n = 1'b0;
            ab_n  = 1'b1;
            rv_n  = 1'b0;
            bv_n  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
            act           <= 1'b0;
            ph            <= PH_RUN;
            scan          <= '0;
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            tx_abort      <= 1'b0;
            tx_done       <= 1'b0;
            snp_out_valid <= 1'b0;
            snp_out_kind  <= MSG_READ;
            snp_out_line  <= '0;
            snp_out_data  <= '0;
        end else begin
            ent           <= ent_n;
            act           <= act_n;
            ph            <= ph_n;
            scan          <= scan_n;
            rsp_valid     <= rv_n;
            rsp_rdata     <= rd_n;
            tx_abort      <= ab_n;
            tx_done       <= dn_n;
            snp_out_valid <= bv_n;
            snp_out_kind  <= bk_n;
            snp_out_line  <= bl_n;
            snp_out_data  <= bd_n;
        end
    end

    assign in_tx = act;

    // R4: abort is a single-cycle pulse
    a_r4_abort_pulse: assert property (@(posedge clk) disable iff (rst)
        tx_abort |=> !tx_abort);
    // R8: no speculative data survives an abort
    a_r8_abort_discards: assert property (@(posedge clk) disable iff (rst)
        tx_abort |-> (dirty_v == '0) && (spec_v == '0) && !in_tx);
    // R3: commit completion leaves no speculative bit behind
    a_r3_done_clean: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (spec_v == '0) && !in_tx);
    // R2: a Modified line is always a speculative one
    a_r2_dirty_is_spec: assert property (@(posedge clk) disable iff (rst)
        (dirty_v & ~spec_v) == '0);
    // R7: speculative-write notices only leave in eager mode
    a_r7_spec_needs_eager: assert property (@(posedge clk) disable iff (rst)
        (snp_out_valid && snp_out_kind == MSG_SPEC) |-> $past(eager_en));
    // R9: no abort unless a transaction was running
    a_r9_idle_no_abort: assert property (@(posedge clk) disable iff (rst)
        !in_tx |=> !tx_abort);
    // R1: a line address is present at most once
    a_r1_single_copy: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_hits));
endmodule

// File: tb/txcache_tb_top.sv
`timescale 1ns/1ps
module txcache_tb_top;
    logic clk = 1'b0;
    logic rst;
    always #2 clk = ~clk;

    logic       beg [2], cmt [2], rqv [2], we [2], eag [2];
    logic [7:0] addr [2], wd [2];
    logic [15:0] fill [2];
    logic       rsp_v [2], intx [2], abo [2], dn [2], sov [2];
    logic [7:0] rsp_d [2];
    logic [1:0] sok [2];
    logic [6:0] sol [2];
    logic [15:0] sod [2];

    logic [15:0] mem [128];
    assign fill[0] = mem[addr[0][7:1]];
    assign fill[1] = mem[addr[1][7:1]];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < 128; l++)
                mem[l] <= {8'({l[6:0], 1'b1}) ^ 8'h5A, 8'({l[6:0], 1'b0}) ^ 8'h5A};
        end else begin
            for (int k = 0; k < 2; k++)
                if (sov[k] && sok[k] == 2'd1) mem[sol[k]] <= sod[k];
        end
    end

    txcache #(.ENTRIES(3), .ADDR_W(8), .DATA_W(8), .WORDS(2)) dut_i (
        .clk(clk), .rst(rst), .eager_en(eag[0]), .tx_begin(beg[0]), .tx_commit(cmt[0]),
        .req_valid(rqv[0]), .req_we(we[0]), .req_addr(addr[0]), .req_wdata(wd[0]),
        .fill_line(fill[0]), .rsp_valid(rsp_v[0]), .rsp_rdata(rsp_d[0]), .in_tx(intx[0]),
        .tx_abort(abo[0]), .tx_done(dn[0]), .snp_out_valid(sov[0]), .snp_out_kind(sok[0]),
        .snp_out_line(sol[0]), .snp_out_data(sod[0]),
        .snp_in_valid(sov[1]), .snp_in_kind(sok[1]), .snp_in_line(sol[1]));

    txcache #(.ENTRIES(3), .ADDR_W(8), .DATA_W(8), .WORDS(2)) peer_i (
        .clk(clk), .rst(rst), .eager_en(eag[1]), .tx_begin(beg[1]), .tx_commit(cmt[1]),
        .req_valid(rqv[1]), .req_we(we[1]), .req_addr(addr[1]), .req_wdata(wd[1]),
        .fill_line(fill[1]), .rsp_valid(rsp_v[1]), .rsp_rdata(rsp_d[1]), .in_tx(intx[1]),
        .tx_abort(abo[1]), .tx_done(dn[1]), .snp_out_valid(sov[1]), .snp_out_kind(sok[1]),
        .snp_out_line(sol[1]), .snp_out_data(sod[1]),
        .snp_in_valid(sov[0]), .snp_in_kind(sok[0]), .snp_in_line(sol[0]));

    int n_cmp = 0;
    int n_bad = 0;
    logic seen_ab [2], seen_dn [2];
    int   mods [2];

    // {store, address, store data, expected load data}, core 0, no transaction
    localparam logic [24:0] VEC [10] = '{
        {1'b0, 8'h10, 8'h00, 8'h4A},
        {1'b1, 8'h10, 8'hA1, 8'h00},
        {1'b0, 8'h10, 8'h00, 8'hA1},
        {1'b0, 8'h11, 8'h00, 8'h4B},
        {1'b1, 8'h21, 8'hB2, 8'h00},
        {1'b0, 8'h30, 8'h00, 8'h6A},
        {1'b0, 8'h40, 8'h00, 8'h1A},
        {1'b0, 8'h10, 8'h00, 8'hA1},
        {1'b0, 8'h21, 8'h00, 8'hB2},
        {1'b0, 8'h20, 8'h00, 8'h7A}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int k = 0; k < 2; k++) begin
            beg[k] = 0; cmt[k] = 0; rqv[k] = 0; we[k] = 0; eag[k] = 0;
            addr[k] = '0; wd[k] = '0;
        end
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic op(input int k, input logic w, input logic [7:0] a, input logic [7:0] d);
        rqv[k] = 1'b1; we[k] = w; addr[k] = a; wd[k] = d;
        tick();
        rqv[k] = 1'b0; we[k] = 1'b0;
    endtask

    task automatic start(input int k);
        beg[k] = 1'b1; tick(); beg[k] = 1'b0;
    endtask

    task automatic start_both();
        beg[0] = 1'b1; beg[1] = 1'b1; tick(); beg[0] = 1'b0; beg[1] = 1'b0;
    endtask

    task automatic finish_tx(input int k);
        cmt[k] = 1'b1; tick(); cmt[k] = 1'b0;
    endtask

    task automatic watch(input int n);
        for (int k = 0; k < 2; k++) begin
            seen_ab[k] = 0; seen_dn[k] = 0; mods[k] = 0;
        end
        for (int c = 0; c < n; c++) begin
            tick();
            for (int k = 0; k < 2; k++) begin
                if (abo[k]) seen_ab[k] = 1;
                if (dn[k]) seen_dn[k] = 1;
                if (sov[k] && sok[k] == 2'd1) mods[k]++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R12 reset state
        chk("R12 in_tx", intx[0], 0);
        chk("R12 abort", abo[0], 0);
        chk("R12 done", dn[0], 0);
        chk("R12 rsp_valid", rsp_v[0], 0);
        chk("R12 bus_valid", sov[0], 0);

        // R9 vector walk outside transactions
        for (int i = 0; i < 10; i++) begin
            op(0, VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
            if (VEC[i][24]) begin
                chk("R9 write-through valid", sov[0], 1);
                chk("R9 write-through kind", sok[0], 1);
            end else begin
                chk("R9 load data", rsp_d[0], VEC[i][7:0]);
            end
            chk("R9 no abort", abo[0], 0);
        end

        // crossed read-A/write-B transactions, lazy mode
        do_reset();
        start_both();
        op(0, 0, 8'h02, 0);
        chk("R1 miss read msg", {sov[0], sok[0]}, {1'b1, 2'd0});
        chk("R1 miss line", sol[0], 1);
        chk("R1 load data", rsp_d[0], 8'h58);
        op(1, 0, 8'h04, 0);
        chk("R1 peer load", rsp_d[1], 8'h5E);
        op(0, 0, 8'h02, 0);
        chk("R1 hit silent", sov[0], 0);
        op(0, 1, 8'h04, 8'h11);
        chk("R2 store miss read only", {sov[0], sok[0]}, {1'b1, 2'd0});
        op(0, 1, 8'h05, 8'h12);
        chk("R2 store hit silent", sov[0], 0);
        op(1, 1, 8'h02, 8'h22);
        chk("R2 memory unchanged", mem[2], 16'h5F5E);
        chk("R2 peer still in tx", intx[1], 1);
        finish_tx(0);
        watch(8);
        chk("R3 commit done", seen_dn[0], 1);
        chk("R3 one notice", mods[0], 1);
        chk("R4 peer aborted", seen_ab[1], 1);
        chk("R4 peer left tx", intx[1], 0);
        chk("R3 memory updated", mem[2], 16'h1211);
        op(1, 0, 8'h02, 0);
        chk("R8 spec store discarded", rsp_d[1], 8'h58);
        op(1, 0, 8'h04, 0);
        chk("R11 stale line refetched", rsp_d[1], 8'h11);
        op(0, 0, 8'h05, 0);
        chk("R3 local committed data", rsp_d[0], 8'h12);
        chk("R3 local hit silent", sov[0], 0);

        // false sharing
        do_reset();
        start_both();
        op(0, 0, 8'h06, 0);
        op(1, 1, 8'h07, 8'h33);
        finish_tx(1);
        watch(6);
        chk("R5 reader aborted", seen_ab[0], 1);
        chk("R5 writer done", seen_dn[1], 1);
        op(0, 0, 8'h07, 0);
        chk("R5 other word new", rsp_d[0], 8'h33);

        // capacity
        do_reset();
        op(0, 0, 8'h40, 0);
        op(0, 0, 8'h42, 0);
        op(0, 0, 8'h44, 0);
        start(0);
        op(0, 0, 8'h50, 0);
        chk("R6 evict clean no abort", abo[0], 0);
        chk("R6 load data", rsp_d[0], 8'h0A);
        op(0, 0, 8'h52, 0);
        op(0, 0, 8'h54, 0);
        chk("R6 third line no abort", abo[0], 0);
        op(0, 0, 8'h56, 0);
        chk("R6 overflow abort", abo[0], 1);
        chk("R6 no data", rsp_v[0], 0);
        chk("R6 left tx", intx[0], 0);
        tick();
        chk("R4 abort one cycle", abo[0], 0);

        // eager notices
        do_reset();
        eag[1] = 1'b1;
        start_both();
        op(0, 0, 8'h08, 0);
        op(1, 1, 8'h08, 8'h44);
        chk("R7 spec notice", {sov[1], sok[1]}, {1'b1, 2'd2});
        tick();
        chk("R7 receiver aborted", abo[0], 1);
        chk("R7 sender stays", intx[1], 1);
        finish_tx(1);
        watch(6);
        chk("R7 sender commits", seen_dn[1], 1);
        chk("R7 memory", mem[4], 16'h5344);

        // begin/commit corner cases
        do_reset();
        finish_tx(0);
        watch(5);
        chk("R10 idle commit no done", seen_dn[0], 0);
        chk("R10 idle commit silent", mods[0], 0);
        start(0);
        op(0, 0, 8'h30, 0);
        start(0);
        chk("R10 still in tx", intx[0], 1);
        op(1, 1, 8'h31, 8'h66);
        watch(3);
        chk("R10 read set kept", seen_ab[0], 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule